// File: doc/BRIEF.md
# Serial Word Loader for a Synthesizer Divider Bank

This block is the programming front end of a frequency synthesizer. Configuration words come in over three slow lines: a serial clock, a serial data line and a latch-enable strobe. All three are sampled in the system clock domain. While the strobe is low, each rising edge of the serial clock pushes one data bit into an 18-bit assembly register. The first bit sent ends up in the most significant position.

When the strobe rises, the assembled word is copied once into one of two parallel registers. The copy happens a fixed number of system clocks after the rise. The lowest bit of the word picks the target. One target is the loop divider setting: a main count, a swallow count and a two-bit control word. The other target is the reference divider setting: a reference count, a charge-pump tristate flag, a phase-detector polarity flag and a test-mode flag. Each field comes out as a separate port. A field keeps its value until its own register is loaded again. The dividers and the charge pump that use these fields sit outside this block.

Top module: `syn_serial_loader`

## Requirements
- R1: After reset, every latched output is zero, and it stays zero until the first transfer.
- R2: Bits are shifted in MSB first. After 18 shifts, the first bit sent sits at word bit 17 and the last bit sent sits at word bit 0.
- R3: When word bit 0 is 0, a transfer loads the divider register from the word: main count = bits 17:8, swallow count = bits 7:3, control = bits 2:1. The reference outputs do not change.
- R4: When word bit 0 is 1, a transfer loads the reference register from the word: reference count = bits 10:1, tristate flag = bit 11, polarity flag = bit 12, test flag = bit 14. The divider outputs do not change.
- R5: A bit is shifted in only on a rising edge of the serial clock, and only while latch enable is low. Serial clock edges while latch enable is high leave the assembled word unchanged.
- R6: A transfer happens once for each rising edge of latch enable and at no other time. Shifting a full new word without a latch-enable rise leaves all outputs unchanged.
- R7: A latch-enable rise that is first seen at one system clock edge shows up at the outputs at the third system clock edge (sync depth 2). The outputs do not change at the second.
- R8: If more than 18 bits are shifted in before a transfer, only the last 18 are kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| ser_clk | input | 1 | Serial bit clock; a bit is taken on its rising edge |
| ser_data | input | 1 | Serial data, MSB first |
| ser_le | input | 1 | Latch enable; a rising edge triggers a transfer |
| n_main_cnt | output | 10 | Divider main count |
| n_swallow_cnt | output | 5 | Divider swallow count |
| n_ctl | output | 2 | Divider control word |
| r_div_cnt | output | 10 | Reference divide count |
| r_cp_tristate | output | 1 | Charge-pump tristate flag |
| r_pd_positive | output | 1 | Phase-detector polarity flag |
| r_test_en | output | 1 | Test-mode flag |

## Verification
The bench builds the block with its default parameters: a 10-bit main count, a 5-bit swallow count, a 2-bit control word, a 10-bit reference count and a two-stage input synchroniser. The whole 18-bit word is therefore only eighteen serial clocks long. This makes every field boundary, the overlength case and the strobe-high case cheap to reach with directed words. With the two-stage synchroniser, the transfer latency is a small exact number of edges, so the bench checks the output cycle by cycle instead of only waiting for it to settle.

// File: rtl/syn_pkg.sv
package syn_pkg;
  localparam int unsigned DEF_B_W    = 10;
  localparam int unsigned DEF_A_W    = 5;
  localparam int unsigned DEF_CTL_W  = 2;
  localparam int unsigned DEF_REF_W  = 10;
  localparam int unsigned DEF_SYNC   = 2;

  typedef enum logic {
    TGT_DIV = 1'b0,
    TGT_REF = 1'b1
  } syn_target_e;
endpackage

// File: rtl/syn_rst_sync.sv
module syn_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign rst_sync_n = chain_q[STAGES-1];
endmodule

// File: rtl/syn_bit_sync.sv
module syn_bit_sync #(
  parameter int unsigned W      = 1,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stage_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    logic [W-1:0] stage_d;
    if (s == 0) begin : g_first
      assign stage_d = d;
    end else begin : g_next
      assign stage_d = stage_q[s-1];
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stage_q[s] <= '0;
      else        stage_q[s] <= stage_d;
    end
  end

  assign q = stage_q[STAGES-1];
endmodule

// File: rtl/syn_shift_reg.sv
module syn_shift_reg #(
  parameter int unsigned SR_W = 18
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            shift_en,
  input  logic            din,
  output logic [SR_W-1:0] word
);
  logic [SR_W-1:0] word_q;
  logic [SR_W-1:0] word_d;

  always_comb begin
    word_d = word_q;
    if (shift_en) word_d = {word_q[SR_W-2:0], din};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) word_q <= '0;
    else        word_q <= word_d;
  end

  assign word = word_q;

  // R5: the word may only move in a cycle that was granted a shift
  p_hold_without_shift_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !shift_en |=> $stable(word_q));
endmodule

// File: rtl/syn_latch_bank.sv
module syn_latch_bank
  import syn_pkg::*;
#(
  parameter int unsigned B_W   = DEF_B_W,
  parameter int unsigned A_W   = DEF_A_W,
  parameter int unsigned CTL_W = DEF_CTL_W,
  parameter int unsigned REF_W = DEF_REF_W
) (
  input  logic                               clk,
  input  logic                               rst_n,
  input  logic                               load,
  input  logic [1+CTL_W+A_W+B_W-1:0]         word,
  output logic [B_W-1:0]                     n_main_cnt,
  output logic [A_W-1:0]                     n_swallow_cnt,
  output logic [CTL_W-1:0]                   n_ctl,
  output logic [REF_W-1:0]                   r_div_cnt,
  output logic                               r_cp_tristate,
  output logic                               r_pd_positive,
  output logic                               r_test_en
);
  localparam int unsigned CTL_LO = 1;
  localparam int unsigned CTL_HI = CTL_LO + CTL_W - 1;
  localparam int unsigned A_LO   = CTL_HI + 1;
  localparam int unsigned A_HI   = A_LO + A_W - 1;
  localparam int unsigned B_LO   = A_HI + 1;
  localparam int unsigned B_HI   = B_LO + B_W - 1;
  localparam int unsigned REF_LO = 1;
  localparam int unsigned REF_HI = REF_LO + REF_W - 1;
  localparam int unsigned TRI_POS = REF_HI + 1;
  localparam int unsigned POL_POS = REF_HI + 2;
  localparam int unsigned TST_POS = REF_HI + 4;

  syn_target_e target;
  logic        load_div;
  logic        load_ref;

  assign target   = syn_target_e'(word[0]);
  assign load_div = load && (target == TGT_DIV);
  assign load_ref = load && (target == TGT_REF);

  logic [B_W-1:0]   b_q, b_d;
  logic [A_W-1:0]   a_q, a_d;
  logic [CTL_W-1:0] c_q, c_d;
  logic [REF_W-1:0] ref_q, ref_d;
  logic             tri_q, tri_d;
  logic             pol_q, pol_d;
  logic             tst_q, tst_d;

  always_comb begin
    b_d = b_q;
    a_d = a_q;
    c_d = c_q;
    if (load_div) begin
      b_d = word[B_HI:B_LO];
      a_d = word[A_HI:A_LO];
      c_d = word[CTL_HI:CTL_LO];
    end
  end

  always_comb begin
    ref_d = ref_q;
    tri_d = tri_q;
    pol_d = pol_q;
    tst_d = tst_q;
    if (load_ref) begin
      ref_d = word[REF_HI:REF_LO];
      tri_d = word[TRI_POS];
      pol_d = word[POL_POS];
      tst_d = word[TST_POS];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      b_q <= '0;
      a_q <= '0;
      c_q <= '0;
    end else begin
      b_q <= b_d;
      a_q <= a_d;
      c_q <= c_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ref_q <= '0;
      tri_q <= 1'b0;
      pol_q <= 1'b0;
      tst_q <= 1'b0;
    end else begin
      ref_q <= ref_d;
      tri_q <= tri_d;
      pol_q <= pol_d;
      tst_q <= tst_d;
    end
  end

  assign n_main_cnt    = b_q;
  assign n_swallow_cnt = a_q;
  assign n_ctl         = c_q;
  assign r_div_cnt     = ref_q;
  assign r_cp_tristate = tri_q;
  assign r_pd_positive = pol_q;
  assign r_test_en     = tst_q;

  // R3: divider fields move only on a transfer addressed to them
  p_div_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !(load && word[0] == 1'b0) |=> ($stable(b_q) && $stable(a_q) && $stable(c_q)));

  // R4: reference fields move only on a transfer addressed to them
  p_ref_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !(load && word[0] == 1'b1) |=>
      ($stable(ref_q) && $stable(tri_q) && $stable(pol_q) && $stable(tst_q)));
endmodule

// File: rtl/syn_serial_loader.sv
module syn_serial_loader
  import syn_pkg::*;
#(
  parameter int unsigned B_W         = DEF_B_W,
  parameter int unsigned A_W         = DEF_A_W,
  parameter int unsigned CTL_W       = DEF_CTL_W,
  parameter int unsigned REF_W       = DEF_REF_W,
  parameter int unsigned SYNC_STAGES = DEF_SYNC
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ser_clk,
  input  logic             ser_data,
  input  logic             ser_le,
  output logic [B_W-1:0]   n_main_cnt,
  output logic [A_W-1:0]   n_swallow_cnt,
  output logic [CTL_W-1:0] n_ctl,
  output logic [REF_W-1:0] r_div_cnt,
  output logic             r_cp_tristate,
  output logic             r_pd_positive,
  output logic             r_test_en
);
  localparam int unsigned SR_W = 1 + CTL_W + A_W + B_W;

  logic       rst_i_n;
  logic [2:0] pins_s;
  logic       sclk_s, sdat_s, le_s;
  logic       sclk_prev_q, sclk_prev_d;
  logic       le_prev_q, le_prev_d;
  logic       shift_en;
  logic       load;
  logic [SR_W-1:0] sr_word;

  syn_rst_sync #(.STAGES(2)) i_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_i_n)
  );

  syn_bit_sync #(.W(3), .STAGES(SYNC_STAGES)) i_pin_sync (
    .clk   (clk),
    .rst_n (rst_i_n),
    .d     ({ser_le, ser_data, ser_clk}),
    .q     (pins_s)
  );

  assign sclk_s = pins_s[0];
  assign sdat_s = pins_s[1];
  assign le_s   = pins_s[2];

  always_comb begin
    sclk_prev_d = sclk_s;
    le_prev_d   = le_s;
  end

  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) begin
      sclk_prev_q <= 1'b0;
      le_prev_q   <= 1'b0;
    end else begin
      sclk_prev_q <= sclk_prev_d;
      le_prev_q   <= le_prev_d;
    end
  end

  assign shift_en = sclk_s && !sclk_prev_q && !le_s;
  assign load     = le_s && !le_prev_q;

  syn_shift_reg #(.SR_W(SR_W)) i_shift (
    .clk      (clk),
    .rst_n    (rst_i_n),
    .shift_en (shift_en),
    .din      (sdat_s),
    .word     (sr_word)
  );

  syn_latch_bank #(
    .B_W   (B_W),
    .A_W   (A_W),
    .CTL_W (CTL_W),
    .REF_W (REF_W)
  ) i_bank (
    .clk           (clk),
    .rst_n         (rst_i_n),
    .load          (load),
    .word          (sr_word),
    .n_main_cnt    (n_main_cnt),
    .n_swallow_cnt (n_swallow_cnt),
    .n_ctl         (n_ctl),
    .r_div_cnt     (r_div_cnt),
    .r_cp_tristate (r_cp_tristate),
    .r_pd_positive (r_pd_positive),
    .r_test_en     (r_test_en)
  );

  // R6: one strobe per latch-enable rise, never two cycles in a row
  p_single_transfer_r6: assert property (@(posedge clk) disable iff (!rst_i_n)
    load |=> !load);

  // R5: while the synchronised strobe is high the assembled word is frozen
  p_frozen_le_high_r5: assert property (@(posedge clk) disable iff (!rst_i_n)
    le_s |=> $stable(sr_word));

  // R1: under reset every latched field reads zero
  p_reset_zero_r1: assert property (@(posedge clk)
    !rst_i_n |-> (n_main_cnt == '0 && r_div_cnt == '0 && !r_test_en));
endmodule

// File: tb/test_syn_serial_loader.sv
module test_syn_serial_loader;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ser_clk = 1'b0;
  logic ser_data = 1'b0;
  logic ser_le = 1'b0;
  logic [9:0] n_main_cnt;
  logic [4:0] n_swallow_cnt;
  logic [1:0] n_ctl;
  logic [9:0] r_div_cnt;
  logic r_cp_tristate, r_pd_positive, r_test_en;

  int n_checks = 0;
  int n_fail   = 0;

  always #2.5 clk = ~clk;

  syn_serial_loader i_syn_serial_loader (
    .clk(clk), .rst_n(rst_n), .ser_clk(ser_clk), .ser_data(ser_data),
    .ser_le(ser_le), .n_main_cnt(n_main_cnt), .n_swallow_cnt(n_swallow_cnt),
    .n_ctl(n_ctl), .r_div_cnt(r_div_cnt), .r_cp_tristate(r_cp_tristate),
    .r_pd_positive(r_pd_positive), .r_test_en(r_test_en)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [17:0] div_word(input logic [9:0] b, input logic [4:0] a,
                                           input logic [1:0] c);
    return {b, a, c, 1'b0};
  endfunction

  function automatic logic [17:0] ref_word(input logic [9:0] cnt, input logic t,
                                           input logic p, input logic x);
    logic [17:0] w = '0;
    w[0] = 1'b1; w[10:1] = cnt; w[11] = t; w[12] = p; w[14] = x;
    return w;
  endfunction

  task automatic wait_clk(input int n);
    for (int i = 0; i < n; i++) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic send_bit(input logic b);
    ser_data = b; ser_clk = 1'b0;
    wait_clk(4);
    ser_clk = 1'b1;
    wait_clk(4);
    ser_clk = 1'b0;
  endtask

  task automatic send_word(input logic [17:0] w);
    for (int i = 17; i >= 0; i--) send_bit(w[i]);
  endtask

  task automatic pulse_le();
    ser_le = 1'b1; wait_clk(6);
    ser_le = 1'b0; wait_clk(6);
  endtask

  task automatic chk_div(input string req, input logic [9:0] b, input logic [4:0] a,
                         input logic [1:0] c);
    chk(req, n_main_cnt, b);
    chk(req, n_swallow_cnt, a);
    chk(req, n_ctl, c);
  endtask

  task automatic chk_ref(input string req, input logic [9:0] cnt, input logic t,
                         input logic p, input logic x);
    chk(req, r_div_cnt, cnt);
    chk(req, {r_cp_tristate, r_pd_positive, r_test_en}, {t, p, x});
  endtask

  task automatic t_reset();
    chk_div("R1", '0, '0, '0);
    chk_ref("R1", '0, 1'b0, 1'b0, 1'b0);
  endtask

  task automatic t_div_load();
    send_word(div_word(10'h2A5, 5'h13, 2'b10));
    pulse_le();
    chk_div("R3", 10'h2A5, 5'h13, 2'b10);
    chk_ref("R3 ref untouched", '0, 1'b0, 1'b0, 1'b0);
  endtask

  task automatic t_ref_load();
    send_word(ref_word(10'h3C1, 1'b1, 1'b0, 1'b1));
    pulse_le();
    chk_ref("R4", 10'h3C1, 1'b1, 1'b0, 1'b1);
    chk_div("R4 div untouched", 10'h2A5, 5'h13, 2'b10);
    send_word(ref_word(10'h002, 1'b0, 1'b1, 1'b0) | 18'h0A000);
    pulse_le();
    chk_ref("R4 unused bits", 10'h002, 1'b0, 1'b1, 1'b0);
  endtask

  task automatic t_msb_first();
    send_word(18'h20000);
    pulse_le();
    chk_div("R2 first bit at 17", 10'h200, 5'h00, 2'b00);
    send_word(18'h00002);
    pulse_le();
    chk_div("R2 late bit low", 10'h000, 5'h00, 2'b01);
  endtask

  task automatic t_overlength();
    for (int i = 0; i < 5; i++) send_bit(1'b1);
    send_word(div_word(10'h155, 5'h0A, 2'b11));
    pulse_le();
    chk_div("R8", 10'h155, 5'h0A, 2'b11);
  endtask

  task automatic t_le_high_ignore();
    send_word(div_word(10'h0F0, 5'h1F, 2'b00));
    ser_le = 1'b1; wait_clk(6);
    for (int i = 0; i < 7; i++) send_bit(1'b1);
    ser_le = 1'b0; wait_clk(6);
    pulse_le();
    chk_div("R5", 10'h0F0, 5'h1F, 2'b00);
  endtask

  task automatic t_no_le_no_change();
    send_word(div_word(10'h3FF, 5'h01, 2'b01));
    wait_clk(10);
    chk_div("R6 no strobe", 10'h0F0, 5'h1F, 2'b00);
    ser_le = 1'b1; wait_clk(30);
    chk_div("R6 strobe held", 10'h3FF, 5'h01, 2'b01);
    ser_le = 1'b0; wait_clk(6);
  endtask

  task automatic t_latency();
    send_word(div_word(10'h011, 5'h02, 2'b10));
    ser_le = 1'b1;
    @(posedge clk); @(posedge clk); @(negedge clk);
    chk_div("R7 not yet", 10'h3FF, 5'h01, 2'b01);
    @(posedge clk); @(negedge clk);
    chk_div("R7 third edge", 10'h011, 5'h02, 2'b10);
    ser_le = 1'b0; wait_clk(6);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    n_checks++; n_fail++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin : main
    wait_clk(3);
    t_reset();
    rst_n = 1'b1;
    wait_clk(5);
    t_reset();
    t_div_load();
    t_ref_load();
    t_msb_first();
    t_overlength();
    t_le_high_ignore();
    t_no_le_no_change();
    t_latency();
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule